// File: doc/BRIEF.md
# Rename-Stage Stall Controller

This block decides, cycle by cycle, what one thread's register-rename stage does with the instructions that decode hands it. It weighs a pipeline flush, a "reorder buffer still unwinding" indication, a resource-stall condition computed elsewhere, and serialize markings carried by the instructions. From these it issues instructions downstream, parks them, or throws them away. It tells decode to hold or to resume with one-cycle pulses, and it shows its current state.

A small skid queue catches everything decode delivers while the stage cannot accept it. The stage empties this queue, oldest first, before it takes fresh decode input again. An instruction marked as serializing is held aside until an external release arrives. It then goes back in at the front of the skid queue, so it is the next instruction to issue. Register lookup, the free list and the arithmetic behind the stall condition are outside the block.

Top module: `rename_stall_ctrl`

## Requirements
- R1: After reset the state is Idle (code 0), both decode handshake outputs are low, no issue lane is valid, the skid level is 0 and the overrun flag is clear.
- R2: A flush or an unwinding indication has the highest priority. On the next cycle the state is Squashing (code 4), the skid queue is empty, no lane issues, and the current input is dropped. The resume pulse fires only if the previous state was Blocked (2), Unblocking (3) or SerializeStall (5).
- R3: With the stall condition high and no flush, the valid decode lanes are appended to the skid queue in lane order. The hold pulse fires unless the state was Blocked or Unblocking. The state becomes Blocked, except that SerializeStall (5) stays SerializeStall.
- R4: In Idle, Running (1) or Squashing, with no stall, the valid lanes (a prefix starting at lane 0) issue on the same-numbered output lanes one cycle later. The state becomes Running, except that Idle with no valid input stays Idle.
- R5: When lane k carries the serialize flag (the per-lane flag input) in the R4 path, lanes below k issue and lane k is held. Lanes above k enter the skid queue, the hold pulse fires, and the state becomes SerializeStall.
- R6: In Blocked or Unblocking, with no stall, up to RW skid entries issue oldest first in that cycle. New decode lanes are appended behind the remaining entries, and Blocked turns into Unblocking.
- R7: Unblocking ends, with a resume pulse and the state Running, in the cycle in which the skid queue is left empty with no new input and no serialize hit.
- R8: In SerializeStall without stall, new lanes go to the skid queue. When the release input is high, the held instruction, with its flag cleared, is put at the head of the skid queue and the state becomes Unblocking, so that this instruction issues before anything queued.
- R9: A skid entry that carries the serialize flag stops the R6 drain. The entries before it issue, it is held, and the state becomes SerializeStall with no hold pulse.
- R10: The skid queue holds 2·DLY·DW + RW entries. Entries beyond that are dropped and the overrun flag is set, and the flag stays set until reset.
- R11: The hold and resume pulses are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | DW | Valid lanes from decode (a prefix from lane 0) |
| dec_serial | input | DW | Per-lane serialize flag |
| dec_payload | input | DW*IW | Per-lane instruction tag, lane 0 in the low bits |
| flush_req | input | 1 | Flush from the retire side |
| rob_draining | input | 1 | Reorder buffer is still unwinding a flush |
| res_stall | input | 1 | Downstream resource stall condition |
| ser_release | input | 1 | The serialize wait is over |
| iss_valid | output | RW | Issued lanes this cycle |
| iss_payload | output | RW*IW | Issued tags, zero on idle lanes |
| hold_decode | output | 1 | One-cycle request for decode to hold |
| release_decode | output | 1 | One-cycle request for decode to resume |
| cur_state | output | 3 | State code: 0 Idle, 1 Running, 2 Blocked, 3 Unblocking, 4 Squashing, 5 SerializeStall |
| skid_level | output | $clog2(DEPTH+1) | Skid queue occupancy |
| skid_overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest situation to reach is a serializing instruction that is already parked in the skid queue behind ordinary work. It must be found by the drain, held, and then put back at the head ahead of entries that arrived later. The stimulus gets there by raising the stall condition while flagged lanes arrive, then lowering it so that the drain meets the flag, and then giving the release while further lanes are still coming in. A long pseudo-random sweep with rare flushes, frequent stalls and scattered flags is checked against a queue model kept in the bench. It drives the same controller through the other interleavings, including head insertion into a nearly full queue.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RUN  = 3'd1,
      ST_BLK  = 3'd2,
      ST_UNB  = 3'd3,
      ST_SQSH = 3'd4,
      ST_SER  = 3'd5
   } rsc_state_e;

   function automatic logic rsc_is_held(input rsc_state_e s);
      return (s == ST_BLK) || (s == ST_UNB);
   endfunction
endpackage

// File: rtl/rsc_scan.sv
module rsc_scan #(
   parameter int LANES = 2,
   localparam int NW = $clog2(LANES + 1)
) (
   input  logic [LANES-1:0] cand_v,
   input  logic [LANES-1:0] cand_s,
   output logic [NW-1:0]    n_pre,
   output logic             hit
);
   // counts leading valid, unflagged lanes; hit marks a flagged lane right after them
   always_comb begin
      int   c;
      logic f;
      c = 0;
      f = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         if (cand_v[i] && !f) begin
            if (cand_s[i]) f = 1'b1;
            else           c = c + 1;
         end
      end
      hit   = f;
      n_pre = NW'(c);
   end
endmodule

// File: rtl/rsc_skid.sv
module rsc_skid #(
   parameter int DEPTH = 6,
   parameter int EW    = 9,
   parameter int PUSH  = 2,
   parameter int HEADS = 2,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int PW = $clog2(HEADS + 1),
   localparam int BW = $clog2(PUSH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [PW-1:0]      pop_n,
   input  logic               hins,
   input  logic [EW-1:0]      hins_ent,
   input  logic [BW-1:0]      push_base,
   input  logic [BW-1:0]      push_n,
   input  logic [PUSH*EW-1:0] push_ent,
   output logic [HEADS*EW-1:0] head_ent,
   output logic [CW-1:0]      cnt,
   output logic               ovf
);
   logic [EW-1:0] mem_q [DEPTH];
   logic [EW-1:0] mem_n [DEPTH];
   logic [EW-1:0] push_arr [PUSH];
   logic [CW-1:0] cnt_q;
   logic          ovf_q;
   int            len_i, total_i;

   initial begin
      assert (HEADS <= DEPTH);
      assert (DEPTH >= 1);
   end

   generate
      for (genvar g = 0; g < PUSH; g++) begin : g_push
         assign push_arr[g] = push_ent[g*EW +: EW];
      end
      for (genvar g = 0; g < HEADS; g++) begin : g_head
         assign head_ent[g*EW +: EW] = mem_q[g];
      end
   endgenerate

   always_comb begin
      len_i   = int'(cnt_q) - int'(pop_n) + (hins ? 1 : 0);
      total_i = len_i + int'(push_n);
   end

   // next image: survivors shifted toward the head (or right by one on head insert), then pushes
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         mem_n[i] = mem_q[i];
         if (i < len_i) begin
            if (hins) begin
               if (i == 0) mem_n[i] = hins_ent;
               else        mem_n[i] = mem_q[(i + DEPTH - 1) % DEPTH];
            end else begin
               for (int j = 0; j < DEPTH; j++)
                  if (j == i + int'(pop_n)) mem_n[i] = mem_q[j];
            end
         end else begin
            for (int p = 0; p < PUSH; p++)
               if ((i - len_i) < int'(push_n) && p == int'(push_base) + (i - len_i))
                  mem_n[i] = push_arr[p];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (flush) begin
         cnt_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
         cnt_q <= (total_i > DEPTH) ? CW'(DEPTH) : CW'(total_i);
         if (total_i > DEPTH) ovf_q <= 1'b1;
      end
   end

   assign cnt = cnt_q;
   assign ovf = ovf_q;

   a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= DEPTH);
   a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);
   a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0));
endmodule

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl
   import rsc_pkg::*;
#(
   parameter int IW  = 8,
   parameter int DW  = 2,
   parameter int RW  = 2,
   parameter int DLY = 1,
   localparam int DEPTH = 2 * DLY * DW + RW,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    dec_valid,
   input  logic [DW-1:0]    dec_serial,
   input  logic [DW*IW-1:0] dec_payload,
   input  logic             flush_req,
   input  logic             rob_draining,
   input  logic             res_stall,
   input  logic             ser_release,
   output logic [RW-1:0]    iss_valid,
   output logic [RW*IW-1:0] iss_payload,
   output logic             hold_decode,
   output logic             release_decode,
   output logic [2:0]       cur_state,
   output logic [CW-1:0]    skid_level,
   output logic             skid_overrun
);
   localparam int EW = IW + 1;
   localparam int PW = $clog2(RW + 1);
   localparam int BW = $clog2(DW + 1);

   initial begin
      assert (RW >= DW);
      assert (DLY >= 1);
      assert (IW >= 1);
   end

   rsc_state_e      st_q, st_n;
   logic [IW-1:0]   held_q, held_n;
   logic [RW-1:0]   ov_q, ov_n;
   logic [RW*IW-1:0] od_q, od_n;
   logic            blk_q, blk_n, unb_q, unb_n;

   logic [EW-1:0]   in_ent   [RW];
   logic [EW-1:0]   head_arr [RW];
   logic [EW-1:0]   cand_ent [RW];
   logic [RW-1:0]   in_v, head_v, cand_v, cand_s;
   logic [RW*EW-1:0] head_flat;
   logic [DW*EW-1:0] push_flat;
   logic            unb_path;
   logic [PW-1:0]   n_pre;
   logic            hit;

   logic            flush;
   logic [PW-1:0]   pop_n;
   logic            hins;
   logic [BW-1:0]   push_base, push_n;
   int              n_in, npre_i;

   assign unb_path = rsc_is_held(st_q);

   generate
      for (genvar g = 0; g < RW; g++) begin : g_lane
         if (g < DW) begin : g_live
            assign in_ent[g] = {dec_serial[g], dec_payload[g*IW +: IW]};
            assign in_v[g]   = dec_valid[g];
         end else begin : g_pad
            assign in_ent[g] = '0;
            assign in_v[g]   = 1'b0;
         end
         assign head_arr[g] = head_flat[g*EW +: EW];
         assign head_v[g]   = int'(skid_level) > g;
         assign cand_ent[g] = unb_path ? head_arr[g] : in_ent[g];
         assign cand_v[g]   = unb_path ? head_v[g] : in_v[g];
         assign cand_s[g]   = cand_ent[g][EW-1];
      end
      for (genvar g = 0; g < DW; g++) begin : g_pk
         assign push_flat[g*EW +: EW] = {dec_serial[g], dec_payload[g*IW +: IW]};
      end
   endgenerate

   rsc_scan #(.LANES(RW)) u_scan (
      .cand_v (cand_v),
      .cand_s (cand_s),
      .n_pre  (n_pre),
      .hit    (hit)
   );

   rsc_skid #(.DEPTH(DEPTH), .EW(EW), .PUSH(DW), .HEADS(RW)) u_skid (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .pop_n     (pop_n),
      .hins      (hins),
      .hins_ent  ({1'b0, held_q}),
      .push_base (push_base),
      .push_n    (push_n),
      .push_ent  (push_flat),
      .head_ent  (head_flat),
      .cnt       (skid_level),
      .ovf       (skid_overrun)
   );

   always_comb begin
      n_in      = $countones(dec_valid);
      npre_i    = int'(n_pre);
      st_n      = st_q;
      held_n    = held_q;
      blk_n     = 1'b0;
      unb_n     = 1'b0;
      ov_n      = '0;
      od_n      = '0;
      flush     = 1'b0;
      pop_n     = '0;
      hins      = 1'b0;
      push_base = '0;
      push_n    = '0;
      if (flush_req || rob_draining) begin
         flush  = 1'b1;
         held_n = '0;
         unb_n  = unb_path || (st_q == ST_SER);
         st_n   = ST_SQSH;
      end else if (res_stall) begin
         push_n = BW'(n_in);
         blk_n  = !unb_path;
         st_n   = (st_q == ST_SER) ? ST_SER : ST_BLK;
      end else if (st_q == ST_SER) begin
         push_n = BW'(n_in);
         if (ser_release) begin
            hins = 1'b1;
            st_n = ST_UNB;
         end
      end else begin
         for (int j = 0; j < RW; j++) begin
            if (j < npre_i) begin
               ov_n[j]           = 1'b1;
               od_n[j*IW +: IW]  = cand_ent[j][IW-1:0];
            end
            if (hit && j == npre_i) held_n = cand_ent[j][IW-1:0];
         end
         if (unb_path) begin
            pop_n  = PW'(npre_i + (hit ? 1 : 0));
            push_n = BW'(n_in);
            if (hit)
               st_n = ST_SER;
            else if (int'(skid_level) == npre_i && n_in == 0) begin
               unb_n = 1'b1;
               st_n  = ST_RUN;
            end else
               st_n = ST_UNB;
         end else if (hit) begin
            push_base = BW'(npre_i + 1);
            push_n    = BW'(n_in - npre_i - 1);
            blk_n     = 1'b1;
            st_n      = ST_SER;
         end else begin
            st_n = (st_q == ST_IDLE && n_in == 0) ? ST_IDLE : ST_RUN;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         held_q <= '0;
         ov_q   <= '0;
         od_q   <= '0;
         blk_q  <= 1'b0;
         unb_q  <= 1'b0;
      end else begin
         st_q   <= st_n;
         held_q <= held_n;
         ov_q   <= ov_n;
         od_q   <= od_n;
         blk_q  <= blk_n;
         unb_q  <= unb_n;
      end
   end

   assign iss_valid      = ov_q;
   assign iss_payload    = od_q;
   assign hold_decode    = blk_q;
   assign release_decode = unb_q;
   assign cur_state      = st_q;

   a_r11_handshake_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(hold_decode && release_decode));
   a_r3_serial_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SER && res_stall && !flush_req && !rob_draining) |=> (st_q == ST_SER));
   a_r2_flush_silences: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req || rob_draining) |=> (st_q == ST_SQSH && iss_valid == '0 && skid_level == '0));
   a_r7_release_state: assert property (@(posedge clk) disable iff (!rst_n)
      release_decode |-> (st_q == ST_RUN || st_q == ST_SQSH));
   a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      st_q inside {ST_IDLE, ST_RUN, ST_BLK, ST_UNB, ST_SQSH, ST_SER});
endmodule

// File: tb/rename_stall_ctrl_test.sv
`timescale 1ns/1ps
module rename_stall_ctrl_test;
   localparam int IW = 8, DW = 2, RW = 2, DLY = 1;
   localparam int DEPTH = 2 * DLY * DW + RW;
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [DW-1:0]    dv, ds;
   logic [DW*IW-1:0] dp;
   logic             fl, rb, rs, sr;
   logic [RW-1:0]    iv;
   logic [RW*IW-1:0] ip;
   logic             hb, hr, ov;
   logic [2:0]       cs;
   logic [CW-1:0]    lvl;

   rename_stall_ctrl #(.IW(IW), .DW(DW), .RW(RW), .DLY(DLY)) uut (
      .clk(clk), .rst_n(rst_n), .dec_valid(dv), .dec_serial(ds), .dec_payload(dp),
      .flush_req(fl), .rob_draining(rb), .res_stall(rs), .ser_release(sr),
      .iss_valid(iv), .iss_payload(ip), .hold_decode(hb), .release_decode(hr),
      .cur_state(cs), .skid_level(lvl), .skid_overrun(ov));

   int vectors = 0, bad = 0, tagc = 1;
   bit finished = 0;
   int m_st, m_held;
   int m_q[$];
   bit m_ovf;
   int e_st;
   bit e_blk, e_unb;
   logic [RW-1:0] e_ov;
   logic [RW*IW-1:0] e_od;
   string e_tag;
   int unsigned seed = 32'h1ace_b00c;

   task automatic chk(string tag, string what, longint act, longint exp);
      vectors++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic qpush(int e);
      if (m_q.size() < DEPTH) m_q.push_back(e);
      else m_ovf = 1;
   endtask

   task automatic predict();
      int inl[$];
      int outs[$];
      int prev;
      bit ovf0, stop;
      prev = m_st; ovf0 = m_ovf; stop = 0;
      for (int j = 0; j < DW; j++)
         if (dv[j]) inl.push_back((int'(ds[j]) << 8) | int'(dp[j*IW +: IW]));
      e_blk = 0; e_unb = 0;
      if (fl || rb) begin
         e_unb = (prev == 2 || prev == 3 || prev == 5);
         m_q.delete(); m_held = 0; m_st = 4; e_tag = "R2";
      end else if (rs) begin
         e_blk = !(prev == 2 || prev == 3);
         foreach (inl[j]) qpush(inl[j]);
         m_st = (prev == 5) ? 5 : 2; e_tag = "R3";
      end else if (prev == 5) begin
         e_tag = "R8";
         if (sr) begin
            m_q.push_front(m_held & 255);
            if (m_q.size() > DEPTH) begin void'(m_q.pop_back()); m_ovf = 1; end
            m_st = 3;
         end
         foreach (inl[j]) qpush(inl[j]);
      end else if (prev == 2 || prev == 3) begin
         e_tag = "R6";
         for (int k = 0; k < RW && m_q.size() > 0 && !stop; k++) begin
            int e;
            e = m_q.pop_front();
            if (e >> 8) begin m_held = e; stop = 1; end
            else outs.push_back(e);
         end
         foreach (inl[j]) qpush(inl[j]);
         if (stop) begin m_st = 5; e_tag = "R9"; end
         else if (m_q.size() == 0) begin e_unb = 1; m_st = 1; e_tag = "R7"; end
         else m_st = 3;
      end else begin
         e_tag = "R4";
         foreach (inl[j]) begin
            if (stop) qpush(inl[j]);
            else if (inl[j] >> 8) begin m_held = inl[j]; stop = 1; end
            else outs.push_back(inl[j]);
         end
         if (stop) begin e_blk = 1; m_st = 5; e_tag = "R5"; end
         else if (!(prev == 0 && inl.size() == 0)) m_st = 1;
      end
      if (m_ovf && !ovf0) e_tag = "R10";
      e_st = m_st; e_ov = '0; e_od = '0;
      foreach (outs[j]) begin
         e_ov[j] = 1'b1;
         e_od[j*IW +: IW] = IW'(outs[j] & 255);
      end
   endtask

   task automatic compare();
      chk(e_tag, "state", cs, e_st);
      chk(e_tag, "hold", hb, e_blk);
      chk(e_tag, "release", hr, e_unb);
      chk(e_tag, "issue_valid", iv, e_ov);
      chk(e_tag, "issue_payload", ip, e_od);
      chk(e_tag, "skid_level", lvl, m_q.size());
      chk("R10", "overrun", ov, m_ovf);
      chk("R11", "hold_and_release", hb & hr, 0);
   endtask

   task automatic drive(int nv, int smask, bit f, bit r, bit s, bit d);
      dv = DW'((1 << nv) - 1);
      ds = DW'(smask) & dv;
      for (int j = 0; j < DW; j++) begin
         dp[j*IW +: IW] = IW'(tagc);
         tagc = (tagc % 250) + 1;
      end
      fl = f; rb = r; rs = s; sr = d;
      predict();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      dv = '0; ds = '0; dp = '0; fl = 0; rb = 0; rs = 0; sr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      m_st = 0; m_q.delete(); m_held = 0; m_ovf = 0;
      chk("R1", "state", cs, 0);
      chk("R1", "hold", hb, 0);
      chk("R1", "release", hr, 0);
      chk("R1", "issue_valid", iv, 0);
      chk("R1", "skid_level", lvl, 0);
      chk("R1", "overrun", ov, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         $display("FAIL R1 watchdog: got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R4: plain issue, idle hold
      drive(0, 0, 0, 0, 0, 0);
      drive(2, 0, 0, 0, 0, 0);
      drive(1, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      // R3, R6, R7: block, then drain
      drive(2, 0, 0, 0, 1, 0);
      drive(2, 0, 0, 0, 1, 0);
      drive(1, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      // R5, R8: serialize in lane 0, release reinserts at head
      drive(2, 1, 0, 0, 0, 0);
      drive(2, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 1, 0);
      drive(0, 0, 0, 0, 1, 1);
      drive(0, 0, 0, 0, 0, 1);
      drive(0, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      // R9: flagged entry parked in skid
      drive(2, 2, 0, 0, 1, 0);
      drive(0, 0, 0, 0, 0, 0);
      drive(1, 0, 0, 0, 0, 1);
      drive(0, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      // R2: flush from Blocked, unwinding, from SerializeStall
      drive(2, 0, 0, 0, 1, 0);
      drive(2, 0, 1, 0, 0, 0);
      drive(2, 0, 0, 1, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      drive(2, 2, 0, 0, 0, 0);
      drive(1, 0, 0, 1, 0, 0);
      drive(2, 0, 0, 0, 0, 0);
      // pseudo-random sweep
      for (int n = 0; n < 4000; n++) begin
         int unsigned r;
         seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
         r = seed;
         drive(int'(r % 3),
               ((r >> 4) & 7) == 0 ? 1 : (((r >> 7) & 3) == 0 ? 2 : 0),
               ((r >> 10) & 63) == 0, ((r >> 16) & 127) == 0,
               ((r >> 23) & 3) == 0, ((r >> 26) & 3) == 0);
      end
      // R10: capacity and sticky overrun
      do_reset();
      for (int n = 0; n < 5; n++) drive(2, 0, 0, 0, 1, 0);
      for (int n = 0; n < 4; n++) drive(0, 0, 0, 0, 0, 0);
      chk("R10", "overrun_sticky", ov, 1);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
   end
endmodule